// File: doc/BRIEF.md
# Shared Display SPI Port Arbiter

This block lets two SPI masters take turns writing to one display that is only ever written to. A small local controller that comes up at once draws the boot screen. A larger host that needs several seconds to boot takes over afterwards. Each master brings its own chip-select, serial clock and data-out into the block. The block forwards exactly one set of these lines to the display port. Data returned from the display is not forwarded.

All master inputs, and the host's sleep request, pass through two-flop synchronizers before the control logic uses them. The block therefore works with a system clock that is much faster than either serial clock.

At reset the local master owns the port. Once a boot hold period of `BOOT_CYCLES` clock cycles has elapsed, the port moves to the host. The host can later raise its sleep request to give the port back to the local master. Lowering the sleep request again hands the port back to the host.

The owner is never switched while the current owner holds its chip-select low. Every switch passes through a guard interval in which the display sees chip-select deasserted. The grant outputs and a busy flag tell each master whether it may start a frame. The local firmware is expected to poll the busy flag, wait, and poll again.

Top module: `spi_share_arbiter`

## Requirements
- R1: Reset state: the local master owns the port. `owner_onehot` is 2'b01, where bit 0 means local and bit 1 means host. `loc_grant` is 1, `hst_grant` is 0 and `disp_cs_n` is 1.
- R2: The port moves to the host once the boot hold has ended, provided the local chip-select (after synchronization) is high and the sleep request is low. `owner_onehot` then reads 2'b10 and `hst_grant` reads 1.
- R3: While the current owner's synchronized chip-select is low, ownership does not change, whatever the boot timer or the sleep request does.
- R4: For `GUARD_CYCLES` cycles between owners, `owner_onehot` is 2'b00, both grants are 0 and `disp_cs_n` is 1.
- R5: While the host owns the port, a high sleep request together with a high host chip-select returns ownership to the local master, by way of the guard interval.
- R6: While the sleep request is high, the local master keeps the port, even in the cycle in which the boot hold ends. Sleep takes priority over boot expiry.
- R7: The display lines follow the owner's chip-select and data with a two-clock latency. The non-owning master's lines have no effect on them. When chip-select is high, `disp_mosi` is 0.
- R8: Whenever `disp_cs_n` is 1, `disp_sck` equals the `CPOL` idle level.
- R9: `loc_busy` is 1 exactly when the local master does not hold the grant.
- R10: `owner_onehot` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_cs_n | input | 1 | Local master chip-select, active low |
| loc_sck | input | 1 | Local master serial clock |
| loc_mosi | input | 1 | Local master data out |
| hst_cs_n | input | 1 | Host master chip-select, active low |
| hst_sck | input | 1 | Host master serial clock |
| hst_mosi | input | 1 | Host master data out |
| hst_sleep | input | 1 | Host request to hand the port back to the local master |
| disp_cs_n | output | 1 | Chip-select to the display |
| disp_sck | output | 1 | Serial clock to the display |
| disp_mosi | output | 1 | Data to the display |
| loc_grant | output | 1 | Local master may drive the port |
| hst_grant | output | 1 | Host master may drive the port |
| loc_busy | output | 1 | Local master must wait before starting a frame |
| owner_onehot | output | 2 | Current owner, bit 0 local, bit 1 host, 00 during guard |

## Verification
The bench builds the block with `BOOT_CYCLES`=40, `GUARD_CYCLES`=4 and `CPOL`=1. The short boot hold puts boot expiry, a boot expiry held back by a busy local master, and a boot expiry that coincides with a sleep request all within a few hundred cycles. A guard of four cycles is long enough to sample the middle of the guard window and its end separately. `CPOL`=1 makes the idle-clock level differ from the reset level of the data lines, so a wrong idle value on the clock shows up.

// File: rtl/spi_share_pkg.sv
package spi_share_pkg;

   typedef enum logic [1:0] {
      ST_LOCAL   = 2'd0,
      ST_TO_HOST = 2'd1,
      ST_HOST    = 2'd2,
      ST_TO_LOC  = 2'd3
   } arb_state_t;

   typedef struct packed {
      logic cs_n;
      logic sck;
      logic mosi;
   } spi_lines_t;

   localparam int OWN_W = 2;

endpackage

// File: rtl/spi_share_sync.sv
module spi_share_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[gi] <= RST_VAL;
            end else if (gi == 0) begin
               chain[gi] <= d;
            end else begin
               chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_share_ctrl.sv
module spi_share_ctrl
   import spi_share_pkg::*;
#(
   parameter int BOOT_CYCLES  = 1000,
   parameter int GUARD_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_cs_n_s,
   input  logic             hst_cs_n_s,
   input  logic             sleep_s,
   output logic [OWN_W-1:0] owner
);

   localparam int BOOT_W  = $clog2(BOOT_CYCLES + 1);
   localparam int GUARD_W = $clog2(GUARD_CYCLES + 1);

   arb_state_t         state, state_nx;
   logic [BOOT_W-1:0]  boot_cnt;
   logic               boot_done;
   logic [GUARD_W-1:0] guard_cnt;
   logic               guard_end;

   // boot hold timer, sticky once expired
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_cnt  <= '0;
         boot_done <= 1'b0;
      end else if (!boot_done) begin
         if (boot_cnt == BOOT_W'(BOOT_CYCLES - 1)) begin
            boot_done <= 1'b1;
         end else begin
            boot_cnt <= boot_cnt + 1'b1;
         end
      end
   end

   assign guard_end = (guard_cnt == GUARD_W'(GUARD_CYCLES - 1));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_LOCAL:   if (boot_done && !sleep_s && loc_cs_n_s) state_nx = ST_TO_HOST;
         ST_TO_HOST: if (guard_end) state_nx = ST_HOST;
         ST_HOST:    if (sleep_s && hst_cs_n_s) state_nx = ST_TO_LOC;
         ST_TO_LOC:  if (guard_end) state_nx = ST_LOCAL;
         default:    state_nx = ST_LOCAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_LOCAL;
         guard_cnt <= '0;
      end else begin
         state <= state_nx;
         if (state_nx != state) begin
            guard_cnt <= '0;
         end else if (!guard_end) begin
            guard_cnt <= guard_cnt + 1'b1;
         end
      end
   end

   always_comb begin
      owner = '0;
      if (state == ST_LOCAL) owner[0] = 1'b1;
      if (state == ST_HOST)  owner[1] = 1'b1;
   end

   a_r10_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner));

   a_r3_local_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCAL && !loc_cs_n_s) |=> (state == ST_LOCAL));

   a_r3_host_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOST && !hst_cs_n_s) |=> (state == ST_HOST));

   a_r6_sleep_holds_local: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCAL && sleep_s) |=> (state == ST_LOCAL));

   a_r5_sleep_handback: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOST && sleep_s && hst_cs_n_s) |=> (state == ST_TO_LOC));

endmodule

// File: rtl/spi_share_mux.sv
module spi_share_mux
   import spi_share_pkg::*;
#(
   parameter logic CPOL = 1'b0
) (
   input  logic [OWN_W-1:0] owner,
   input  spi_lines_t       loc_in,
   input  spi_lines_t       hst_in,
   output spi_lines_t       disp_out
);

   spi_lines_t sel;

   always_comb begin
      sel = '{cs_n: 1'b1, sck: CPOL, mosi: 1'b0};
      if (owner[0]) sel = loc_in;
      else if (owner[1]) sel = hst_in;
   end

   always_comb begin
      disp_out.cs_n = sel.cs_n;
      disp_out.sck  = sel.cs_n ? CPOL : sel.sck;
      disp_out.mosi = sel.cs_n ? 1'b0 : sel.mosi;
   end

endmodule

// File: rtl/spi_share_arbiter.sv
module spi_share_arbiter
   import spi_share_pkg::*;
#(
   parameter int   BOOT_CYCLES  = 1000,
   parameter int   GUARD_CYCLES = 8,
   parameter logic CPOL         = 1'b0,
   parameter int   SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       loc_cs_n,
   input  logic       loc_sck,
   input  logic       loc_mosi,
   input  logic       hst_cs_n,
   input  logic       hst_sck,
   input  logic       hst_mosi,
   input  logic       hst_sleep,
   output logic       disp_cs_n,
   output logic       disp_sck,
   output logic       disp_mosi,
   output logic       loc_grant,
   output logic       hst_grant,
   output logic       loc_busy,
   output logic [1:0] owner_onehot
);

   localparam int        SYNC_W   = 7;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, CPOL, 1'b0, 1'b1, CPOL, 1'b0};

   generate
      if (BOOT_CYCLES < 2) begin : g_bad_boot
         $error("BOOT_CYCLES must be at least 2");
      end
      if (GUARD_CYCLES < 1) begin : g_bad_guard
         $error("GUARD_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_bus, sync_bus;
   spi_lines_t        loc_s, hst_s, disp_l;
   logic              sleep_s;
   logic [OWN_W-1:0]  owner;

   assign raw_bus = {hst_sleep, hst_cs_n, hst_sck, hst_mosi, loc_cs_n, loc_sck, loc_mosi};

   spi_share_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   assign sleep_s = sync_bus[6];
   assign hst_s   = '{cs_n: sync_bus[5], sck: sync_bus[4], mosi: sync_bus[3]};
   assign loc_s   = '{cs_n: sync_bus[2], sck: sync_bus[1], mosi: sync_bus[0]};

   spi_share_ctrl #(
      .BOOT_CYCLES  (BOOT_CYCLES),
      .GUARD_CYCLES (GUARD_CYCLES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .loc_cs_n_s (loc_s.cs_n),
      .hst_cs_n_s (hst_s.cs_n),
      .sleep_s    (sleep_s),
      .owner      (owner)
   );

   spi_share_mux #(
      .CPOL (CPOL)
   ) u_mux (
      .owner    (owner),
      .loc_in   (loc_s),
      .hst_in   (hst_s),
      .disp_out (disp_l)
   );

   assign disp_cs_n    = disp_l.cs_n;
   assign disp_sck     = disp_l.sck;
   assign disp_mosi    = disp_l.mosi;
   assign loc_grant    = owner[0];
   assign hst_grant    = owner[1];
   assign loc_busy     = ~owner[0];
   assign owner_onehot = owner;

   a_r4_guard_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_onehot == 2'b00) |-> disp_cs_n);

   a_r8_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
      disp_cs_n |-> (disp_sck == CPOL));

   a_r7_no_cross_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_grant && hst_grant));

endmodule

// File: tb/spi_share_arbiter_test.sv
`timescale 1ns/1ps
module spi_share_arbiter_test;

   localparam int   BOOT  = 40;
   localparam int   GUARD = 4;
   localparam logic CP    = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic loc_cs_n = 1'b1, loc_sck = CP, loc_mosi = 1'b0;
   logic hst_cs_n = 1'b1, hst_sck = CP, hst_mosi = 1'b0;
   logic hst_sleep = 1'b0;
   logic disp_cs_n, disp_sck, disp_mosi, loc_grant, hst_grant, loc_busy;
   logic [1:0] owner_onehot;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   spi_share_arbiter #(
      .BOOT_CYCLES  (BOOT),
      .GUARD_CYCLES (GUARD),
      .CPOL         (CP)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .loc_cs_n (loc_cs_n), .loc_sck (loc_sck), .loc_mosi (loc_mosi),
      .hst_cs_n (hst_cs_n), .hst_sck (hst_sck), .hst_mosi (hst_mosi),
      .hst_sleep (hst_sleep),
      .disp_cs_n (disp_cs_n), .disp_sck (disp_sck), .disp_mosi (disp_mosi),
      .loc_grant (loc_grant), .hst_grant (hst_grant), .loc_busy (loc_busy),
      .owner_onehot (owner_onehot)
   );

   function automatic logic exp_sck(logic cs, logic sck);
      return cs ? CP : sck;
   endfunction

   function automatic logic exp_mosi(logic cs, logic d);
      return cs ? 1'b0 : d;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(logic slp);
      rst_n = 1'b0;
      loc_cs_n = 1'b1; hst_cs_n = 1'b1; hst_sleep = slp;
      step(2);
      rst_n = 1'b1;
   endtask

   // random frames on both masters; expect owner's lines two cycles later
   task automatic route_burst(bit host_owns, int n);
      for (int i = 0; i < n; i++) begin
         logic lc, ls, lm, hc, hs, hm;
         lc = 1'($urandom); ls = 1'($urandom); lm = 1'($urandom);
         hc = 1'($urandom); hs = 1'($urandom); hm = 1'($urandom);
         if (host_owns) lc = 1'b0; else hc = 1'b0;
         loc_cs_n = lc; loc_sck = ls; loc_mosi = lm;
         hst_cs_n = hc; hst_sck = hs; hst_mosi = hm;
         step(2);
         if (host_owns) begin
            chk("R7 cs", disp_cs_n, hc);
            chk("R7 mosi", disp_mosi, exp_mosi(hc, hm));
            chk("R8 sck", disp_sck, exp_sck(hc, hs));
            chk("R9 busy", loc_busy, 1);
         end else begin
            chk("R7 cs", disp_cs_n, lc);
            chk("R7 mosi", disp_mosi, exp_mosi(lc, lm));
            chk("R8 sck", disp_sck, exp_sck(lc, ls));
            chk("R9 busy", loc_busy, 0);
         end
         chk("R10 onehot", $countones(owner_onehot) <= 1, 1);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      // R1 reset state
      do_reset(1'b0);
      step(1);
      chk("R1 owner", owner_onehot, 2'b01);
      chk("R1 loc_grant", loc_grant, 1);
      chk("R1 hst_grant", hst_grant, 0);
      chk("R1 disp_cs_n", disp_cs_n, 1);
      chk("R8 idle sck", disp_sck, CP);

      // R3: local frame spans boot expiry
      loc_cs_n = 1'b0;
      step(BOOT + 20);
      chk("R3 local kept", owner_onehot, 2'b01);
      chk("R3 disp_cs_n", disp_cs_n, 0);
      loc_cs_n = 1'b1;
      step(4);
      chk("R4 guard owner", owner_onehot, 2'b00);
      chk("R4 guard grants", {loc_grant, hst_grant}, 0);
      chk("R4 guard cs", disp_cs_n, 1);
      hst_cs_n = 1'b0; hst_sck = 1'b0;
      step(1);
      chk("R4 guard masks host cs", disp_cs_n, 1);
      chk("R8 guard sck", disp_sck, CP);
      step(3);
      chk("R2 host owner", owner_onehot, 2'b10);
      chk("R2 hst_grant", hst_grant, 1);
      route_burst(1'b1, 40);

      // R3 host busy with sleep, then R5 handback
      hst_cs_n = 1'b0;
      hst_sleep = 1'b1;
      step(12);
      chk("R3 host kept", owner_onehot, 2'b10);
      hst_cs_n = 1'b1;
      step(4);
      chk("R4 guard to local", owner_onehot, 2'b00);
      step(4);
      chk("R5 local back", owner_onehot, 2'b01);
      route_burst(1'b0, 40);

      // R6: sleep held across boot expiry
      do_reset(1'b1);
      step(BOOT + 20);
      chk("R6 sleep wins", owner_onehot, 2'b01);
      chk("R6 loc_busy", loc_busy, 0);
      hst_sleep = 1'b0;
      step(3 + GUARD + 2);
      chk("R2 after wake", owner_onehot, 2'b10);

      // R2 directed: boot expiry with idle local
      do_reset(1'b0);
      step(BOOT - 10);
      chk("R2 before boot end", owner_onehot, 2'b01);
      step(30);
      chk("R2 after boot end", owner_onehot, 2'b10);
      chk("R9 busy under host", loc_busy, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule